// File: doc/BRIEF.md
# Multi-Lane SPI Slave Word Transceiver

This block is the serial front end of a bridge that lets an external SPI master reach an on-chip bus. It exchanges fixed 32-bit words with the master over one, two or four data lines. It moves each word between the serial clock domain and a much faster system clock domain. Only one timing mode exists: the serial clock idles low, the block samples incoming lines on the falling edge, and it changes its outgoing lines on the rising edge. The system clock must run at least 2.4 times faster than the serial clock.

Each frame, framed by an active-low select, carries one word, most significant group first. A frame is inbound by default, and its word is offered to the system side on a valid/ready pair. When the system side has handed over a read word and the serial side has seen it, the next frame is outbound: the block drives that word on the lanes of the selected width, and the frame delivers no inbound word. Raising the select mid-frame abandons the frame. All handshake toggles cross the domains through two-flop synchronisers. Each data register stays stable until the matching acknowledge has returned.

Top module: `spi_frame_engine`

## Requirements
- R1: With lane_mode 0 (single), an inbound frame is 32 falling edges of sclk; IO0 carries one bit per edge, most significant bit first, and the assembled word appears on rx_data with rx_valid.
- R2: With lane_mode 1 (dual), an inbound frame is 16 falling edges; each edge takes two bits, IO1 holding the higher bit of the pair.
- R3: With lane_mode 2 (quad), an inbound frame is 8 falling edges; each edge takes four bits, IO3 highest and IO0 lowest.
- R4: In an outbound frame the block updates io_out on each rising edge of sclk, most significant group first. Single mode uses IO1, dual uses IO1:IO0 with IO1 higher, and quad uses IO3:IO0 with IO3 highest.
- R5: io_oe is 0 whenever cs_n is high and throughout inbound frames; in an outbound frame it is 4'b0010 (single), 4'b0011 (dual) or 4'b1111 (quad).
- R6: A frame is outbound exactly when a read word was pending on the serial side at its first rising edge. The serial side sees a word accepted on tx_valid/tx_ready after two falling edges of sclk. A completed outbound frame consumes the word and raises no rx_valid.
- R7: Raising cs_n before the last group of a frame discards the partial word and restarts the group count. A partial inbound word never raises rx_valid, and an interrupted outbound frame leaves its read word pending for the next frame.
- R8: rx_valid stays high with rx_data unchanged until rx_ready is high in the same cycle. It then falls in the next cycle, and each completed inbound frame is presented at most once.
- R9: An inbound frame that completes while the previous word has not yet been acknowledged back on the serial side is dropped; rx_data keeps the earlier word.
- R10: tx_ready falls the cycle after a word is accepted and stays low until the outbound frame carrying that word has completed and the acknowledge has crossed back.

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| lane_mode | input | 2 | Lane width: 0 single, 1 dual, 2 quad, 3 acts as quad; held constant while cs_n is low |
| sclk | input | 1 | Serial clock from the master, idles low |
| cs_n | input | 1 | Active-low frame select |
| io_in | input | 4 | Sampled levels of the four data pads |
| io_out | output | 4 | Values driven onto the data pads |
| io_oe | output | 4 | Per-pad output enable |
| rx_valid | output | 1 | An inbound word is offered |
| rx_ready | input | 1 | System side takes the inbound word |
| rx_data | output | 32 | Inbound word |
| tx_valid | input | 1 | System side offers a read word |
| tx_ready | output | 1 | The block can take a read word |
| tx_data | input | 32 | Read word to be sent out |

## Verification
Assertions check several properties on every cycle. The group counter stays below the group count of the active width. Outbound frames only end with a pending word. A dropped frame leaves rx_data untouched. Both handshakes obey their hold and release rules. The bench scenarios show things no single-cycle property can express: the lane ordering and bit order of whole words in each width, and the choice between inbound and outbound frames. They also show that an aborted frame leaves no trace, and that a word lost to overflow is really gone after the earlier one is taken.

// File: rtl/spife_pkg.sv
package spife_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    LANE_X1  = 2'd0,
    LANE_X2  = 2'd1,
    LANE_X4  = 2'd2,
    LANE_X4R = 2'd3
  } lane_mode_e;

  // number of data lines carrying bits in this width
  function automatic int unsigned lane_count(lane_mode_e m);
    case (m)
      LANE_X1: return 1;
      LANE_X2: return 2;
      default: return 4;
    endcase
  endfunction

  // serial clock periods per frame
  function automatic int unsigned group_count(lane_mode_e m);
    return WORD_W / lane_count(m);
  endfunction

  // pads that turn into outputs during an outbound frame
  function automatic logic [3:0] oe_mask(lane_mode_e m);
    case (m)
      LANE_X1: return 4'b0010;
      LANE_X2: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // append one sampled group below the bits already received
  function automatic logic [WORD_W-1:0] shift_in(logic [WORD_W-1:0] cur,
                                                 logic [3:0] pads,
                                                 lane_mode_e m);
    logic [3:0] keep;
    keep = 4'((1 << lane_count(m)) - 1);
    if (m == LANE_X1) keep = 4'b0001;
    return (cur << lane_count(m)) | {{(WORD_W-4){1'b0}}, pads & keep};
  endfunction

  // pad values for outbound group idx (0 = most significant group)
  function automatic logic [3:0] group_out(logic [WORD_W-1:0] word,
                                           lane_mode_e m,
                                           logic [CNT_W-1:0] idx);
    logic [WORD_W-1:0] sh;
    int unsigned amt;
    amt = 32'(idx) * lane_count(m);
    sh  = word << amt;
    case (m)
      LANE_X1: return {2'b00, sh[WORD_W-1], 1'b0};
      LANE_X2: return {2'b00, sh[WORD_W-1 -: 2]};
      default: return sh[WORD_W-1 -: 4];
    endcase
  endfunction

endpackage

// File: rtl/spife_sync.sv
module spife_sync #(
  parameter int STAGES    = 2,
  parameter bit FALL_EDGE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (FALL_EDGE) begin : g_fall
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spife_serial.sv
module spife_serial
  import spife_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  lane_mode_e        mode,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tx_req,
  input  logic              rx_ack,
  output logic [WORD_W-1:0] rx_word,
  output logic              rx_req,
  output logic              tx_ack
);

  logic frame_clr;
  assign frame_clr = cs_n | ~rst_n;

  logic tx_req_s, rx_ack_s;

  spife_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_tx_req_sync (
    .clk(sclk), .rst_n(rst_n), .d(tx_req), .q(tx_req_s)
  );
  spife_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b1)) u_rx_ack_sync (
    .clk(sclk), .rst_n(rst_n), .d(rx_ack), .q(rx_ack_s)
  );

  logic [CNT_W-1:0]  rx_cnt, tx_cnt;
  logic [WORD_W-1:0] rx_shift, rx_next;
  logic              rd_frame;
  logic              frame_done, tx_avail, rx_room, word_drop;

  assign rx_next    = shift_in(rx_shift, io_in, mode);
  assign frame_done = !cs_n && (32'(rx_cnt) == group_count(mode) - 1);
  assign tx_avail   = tx_req_s ^ tx_ack;
  assign rx_room    = (rx_req == rx_ack_s);
  assign word_drop  = frame_done && !rd_frame && !rx_room;

  // falling edge: sample lanes, count groups
  always_ff @(negedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      rx_cnt   <= '0;
      rx_shift <= '0;
    end else begin
      rx_shift <= rx_next;
      rx_cnt   <= frame_done ? '0 : rx_cnt + 1'b1;
    end
  end

  // falling edge: end of frame, hand off word or release read word
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rx_word <= '0;
      rx_req  <= 1'b0;
      tx_ack  <= 1'b0;
    end else if (frame_done) begin
      if (rd_frame) begin
        tx_ack <= ~tx_ack;
      end else if (rx_room) begin
        rx_word <= rx_next;
        rx_req  <= ~rx_req;
      end
    end
  end

  // rising edge: choose direction at group 0, drive outbound group
  always_ff @(posedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      tx_cnt   <= '0;
      rd_frame <= 1'b0;
      io_out   <= '0;
    end else begin
      if (tx_cnt == '0) rd_frame <= tx_avail;
      io_out <= group_out(tx_word, mode, tx_cnt);
      tx_cnt <= (32'(tx_cnt) == group_count(mode) - 1) ? '0 : tx_cnt + 1'b1;
    end
  end

  assign io_oe = (rd_frame && !cs_n) ? oe_mask(mode) : 4'b0000;

  assert_count_in_range_R3: assert property (
    @(negedge sclk) disable iff (frame_clr)
    32'(rx_cnt) < group_count(mode)
  );

  assert_read_needs_word_R6: assert property (
    @(negedge sclk) disable iff (frame_clr)
    (frame_done && rd_frame) |-> tx_avail
  );

  assert_drop_keeps_word_R9: assert property (
    @(negedge sclk) disable iff (!rst_n)
    word_drop |=> $stable(rx_word)
  );

endmodule

// File: rtl/spife_sysport.sv
module spife_sysport
  import spife_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_req,
  input  logic              tx_ack,
  input  logic              rx_ready,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic              tx_ready,
  output logic [WORD_W-1:0] tx_word,
  output logic              tx_req,
  output logic              rx_ack
);

  logic rx_req_s, tx_ack_s;

  spife_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_rx_req_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_req), .q(rx_req_s)
  );
  spife_sync #(.STAGES(SYNC_STAGES), .FALL_EDGE(1'b0)) u_tx_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(tx_ack), .q(tx_ack_s)
  );

  logic rx_take, tx_take;
  assign rx_valid = rx_req_s ^ rx_ack;
  assign tx_ready = (tx_req == tx_ack_s);
  assign rx_take  = rx_valid && rx_ready;
  assign tx_take  = tx_valid && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ack  <= 1'b0;
      tx_req  <= 1'b0;
      tx_word <= '0;
    end else begin
      if (rx_take) rx_ack <= ~rx_ack;
      if (tx_take) begin
        tx_word <= tx_data;
        tx_req  <= ~tx_req;
      end
    end
  end

  assert_rx_release_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    rx_take |=> !rx_valid
  );

  assert_tx_busy_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_ready
  );

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spife_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  lane_mode,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic [3:0]  io_in,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [31:0] rx_data,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [31:0] tx_data
);

  lane_mode_e        mode_e;
  logic              rx_req_t, rx_ack_t, tx_req_t, tx_ack_t;
  logic [WORD_W-1:0] tx_word_q, rx_word_q;

  assign mode_e = lane_mode_e'(lane_mode);

  spife_serial #(.SYNC_STAGES(SYNC_STAGES)) u_serial (
    .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mode(mode_e),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .tx_word(tx_word_q), .tx_req(tx_req_t), .rx_ack(rx_ack_t),
    .rx_word(rx_word_q), .rx_req(rx_req_t), .tx_ack(tx_ack_t)
  );

  spife_sysport #(.SYNC_STAGES(SYNC_STAGES)) u_sysport (
    .clk(clk), .rst_n(rst_n), .rx_req(rx_req_t), .tx_ack(tx_ack_t),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .tx_ready(tx_ready), .tx_word(tx_word_q),
    .tx_req(tx_req_t), .rx_ack(rx_ack_t)
  );

  assign rx_data = rx_word_q;

  assert_rx_hold_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))
  );

  assert_idle_no_drive_R5: assert property (
    @(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000)
  );

endmodule

// File: tb/sim_spi_frame_engine.sv
module sim_spi_frame_engine;

  localparam int CLK_P = 10;
  localparam int HALF  = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  lane_mode = 2'd0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic [3:0]  io_in = 4'd0;
  logic [3:0]  io_out, io_oe;
  logic        rx_valid, tx_ready;
  logic        rx_ready = 1'b0;
  logic        tx_valid = 1'b0;
  logic [31:0] rx_data;
  logic [31:0] tx_data = 32'd0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  spi_frame_engine u0 (
    .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .sclk(sclk), .cs_n(cs_n),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int nlanes(logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [3:0] exp_oe(logic [1:0] m);
    if (m == 2'd0) return 4'b0010;
    if (m == 2'd1) return 4'b0011;
    return 4'b1111;
  endfunction

  // master-side lane pattern for group g of word w
  function automatic logic [3:0] mst_pads(logic [1:0] m, logic [31:0] w, int g);
    int l;
    logic [31:0] s;
    l = nlanes(m);
    s = w >> (32 - l * (g + 1));
    return s[3:0] & 4'((1 << l) - 1);
  endfunction

  // bits the master reads back from the pads
  function automatic logic [31:0] pads_to_bits(logic [1:0] m, logic [3:0] p);
    if (m == 2'd0) return {31'd0, p[1]};
    if (m == 2'd1) return {30'd0, p[1:0]};
    return {28'd0, p};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one frame; stop_at < groups aborts before that group
  task automatic spi_frame(input logic [1:0] m, input logic [31:0] mosi,
                           input int stop_at, output logic [31:0] miso,
                           output logic [3:0] oe_seen, output bit oe_mixed);
    int g_total;
    g_total = 32 / nlanes(m);
    miso = 32'd0;
    oe_mixed = 1'b0;
    oe_seen = 4'd0;
    lane_mode = m;
    cs_n = 1'b0;
    #(HALF);
    for (int g = 0; g < g_total; g++) begin
      if (g == stop_at) break;
      sclk = 1'b1;
      #2;
      io_in = mst_pads(m, mosi, g);
      #(HALF - 4);
      miso = (miso << nlanes(m)) | pads_to_bits(m, io_out);
      if (g == 0) oe_seen = io_oe;
      else if (io_oe != oe_seen) oe_mixed = 1'b1;
      #2;
      sclk = 1'b0;
      #(HALF);
    end
    cs_n = 1'b1;
    io_in = 4'd0;
    #(HALF);
  endtask

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic take_rx(input logic [31:0] exp, input string req);
    wait_clks(8);
    check(rx_valid === 1'b1, req, {31'd0, rx_valid}, 32'd1);
    check(rx_data === exp, req, rx_data, exp);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    check(rx_valid === 1'b0, "R8", {31'd0, rx_valid}, 32'd0);
  endtask

  task automatic load_tx(input logic [31:0] w);
    @(negedge clk);
    check(tx_ready === 1'b1, "R10", {31'd0, tx_ready}, 32'd1);
    tx_data = w;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check(tx_ready === 1'b0, "R10", {31'd0, tx_ready}, 32'd0);
  endtask

  task automatic write_and_check(input logic [1:0] m, input logic [31:0] w);
    logic [31:0] miso;
    logic [3:0] oe;
    bit mixed;
    string req;
    req = (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : "R3";
    spi_frame(m, w, 99, miso, oe, mixed);
    check(oe == 4'd0 && !mixed, "R5", {28'd0, oe}, 32'd0);
    take_rx(w, req);
  endtask

  // load, prime with an inbound frame, then an outbound frame
  task automatic read_and_check(input logic [1:0] m, input logic [31:0] w);
    logic [31:0] miso, filler;
    logic [3:0] oe;
    bit mixed;
    load_tx(w);
    filler = $urandom;
    spi_frame(m, filler, 99, miso, oe, mixed);
    check(oe == 4'd0, "R6", {28'd0, oe}, 32'd0);
    take_rx(filler, "R6");
    spi_frame(m, $urandom, 99, miso, oe, mixed);
    check(miso === w, "R4", miso, w);
    check(oe === exp_oe(m) && !mixed, "R5", {28'd0, oe}, {28'd0, exp_oe(m)});
    wait_clks(8);
    check(rx_valid === 1'b0, "R6", {31'd0, rx_valid}, 32'd0);
    check(tx_ready === 1'b1, "R10", {31'd0, tx_ready}, 32'd1);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] miso, w1, w2;
    logic [3:0] oe;
    bit mixed;
    void'($urandom(32'h1f2e3d4c));

    wait_clks(5);
    rst_n = 1'b1;
    wait_clks(2);
    // reset state
    check(rx_valid === 1'b0, "R8", {31'd0, rx_valid}, 32'd0);
    check(tx_ready === 1'b1, "R10", {31'd0, tx_ready}, 32'd1);
    check(io_oe === 4'd0, "R5", {28'd0, io_oe}, 32'd0);

    // directed inbound words, one per width (R1 R2 R3)
    write_and_check(2'd0, 32'h8000_0001);
    write_and_check(2'd1, 32'hA5C3_0F81);
    write_and_check(2'd2, 32'h1234_5678);
    // random inbound words
    for (int i = 0; i < 18; i++) begin
      write_and_check(2'($urandom % 3), $urandom);
    end

    // outbound frames in every width (R4 R5 R6 R10)
    read_and_check(2'd0, 32'hC000_0003);
    read_and_check(2'd1, 32'h9E37_79B9);
    read_and_check(2'd2, 32'hF0E1_D2C3);
    for (int i = 0; i < 4; i++) read_and_check(2'($urandom % 3), $urandom);

    // aborted inbound frame then a full one (R7)
    for (int m = 0; m < 3; m++) begin
      int gt;
      gt = 32 / nlanes(2'(m));
      w1 = $urandom;
      w2 = $urandom;
      spi_frame(2'(m), w1, 1 + int'($urandom % (gt - 1)), miso, oe, mixed);
      wait_clks(8);
      check(rx_valid === 1'b0, "R7", {31'd0, rx_valid}, 32'd0);
      write_and_check(2'(m), w2);
    end

    // aborted outbound frame keeps the read word (R7)
    w1 = 32'h6B2D_90E4;
    load_tx(w1);
    w2 = $urandom;
    spi_frame(2'd2, w2, 99, miso, oe, mixed);
    take_rx(w2, "R7");
    spi_frame(2'd2, 32'd0, 3, miso, oe, mixed);
    wait_clks(8);
    check(tx_ready === 1'b0, "R7", {31'd0, tx_ready}, 32'd0);
    spi_frame(2'd2, 32'd0, 99, miso, oe, mixed);
    check(miso === w1, "R7", miso, w1);
    wait_clks(8);
    check(tx_ready === 1'b1, "R10", {31'd0, tx_ready}, 32'd1);

    // overflow: second word dropped (R9)
    w1 = 32'h0BAD_F00D;
    w2 = 32'hDEAD_0123;
    spi_frame(2'd1, w1, 99, miso, oe, mixed);
    spi_frame(2'd1, w2, 99, miso, oe, mixed);
    wait_clks(8);
    check(rx_data === w1, "R9", rx_data, w1);
    take_rx(w1, "R9");
    wait_clks(8);
    check(rx_valid === 1'b0, "R9", {31'd0, rx_valid}, 32'd0);
    write_and_check(2'd1, 32'h5A5A_1234);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule